// File: doc/BRIEF.md
# Programmable AND-OR Logic Array

This block models a small fuse-programmed logic device inside a larger chip. While `cfg_mode_i` is high, a 2048-bit fuse map is written one bit at a time through an address/data port. In run mode, sixteen array signals drive 64 product terms. Eight are input pins and eight are feedback from the output cells. The terms are summed in groups of eight by eight output macrocells, and each macrocell drives one output pin position.

The parameter `NUM_REGS` selects the flavour. With 0, every macrocell is combinational and the array has ten dedicated inputs. The two end cells act as dedicated outputs and the middle six as bidirectional I/O. With 4, 6 or 8, that many central macrocells become clocked registers, the remaining cells stay combinational I/O, and the array has eight dedicated inputs. A three-state pad is modelled as a data output plus an enable output. The resolved pad level comes back on `pin_i`.

Top module: `pal_array`

## Requirements
- R1: After reset every fuse is intact (1), every register is 0, every pin_o bit is 1, and pin_oe_o is 0 while oe_ni is high.
- R2: A fuse write (fuse_we_i high) stores fuse_data_i at bit fuse_addr_i[4:0] of row fuse_addr_i[10:5], visible from the next cycle. It takes effect only while cfg_mode_i is high and is ignored in run mode.
- R3: A product term is the AND of every column literal whose fuse is 1. A row with every fuse at 0 is always true. A row with every fuse at 1 is always false.
- R4: Signal slot k (0..7) owns four columns. Column 4k is dedicated input k, 4k+1 its complement, 4k+2 the feedback of macrocell k, and 4k+3 that feedback's complement.
- R5: Macrocell m owns rows 8m..8m+7 and drives pin position m. In a combinational cell, row 8m is the pin enable and rows 8m+1..8m+7 are ORed. pin_o[m] is the inverse of that OR.
- R6: A registered cell captures the OR of all eight of its rows on the rising clock edge. Its pin_o is the inverse of the register, and its pin_oe_o is the inverse of oe_ni.
- R7: A registered cell's feedback columns carry its register state. A combinational I/O cell's feedback columns carry pin_i[m].
- R8: While cfg_mode_i is high, every pin_oe_o bit is 0 and the registers hold. The first clock edge after cfg_mode_i falls clears every register to 0.
- R9: With NUM_REGS of 4, 6 or 8, the registered cells are the central ones, starting at cell (8-NUM_REGS)/2. With NUM_REGS 0, the feedback columns of cells 0 and 7 carry in_i[8] and in_i[9].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for registered cells and fuse writes |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_mode_i | input | 1 | High selects configuration mode |
| fuse_we_i | input | 1 | Fuse write strobe |
| fuse_addr_i | input | 11 | Fuse number: row in [10:5], column in [4:0] |
| fuse_data_i | input | 1 | Fuse value, 1 means intact |
| in_i | input | 10 if NUM_REGS is 0, else 8 | Dedicated inputs |
| oe_ni | input | 1 | Shared active-low enable for registered pins |
| pin_i | input | 8 | Resolved pad level per pin position |
| pin_o | output | 8 | Pin data per macrocell |
| pin_oe_o | output | 8 | Pin driver enable per macrocell |

## Verification
Register capture and leaving configuration can fall on the same clock edge: a cell's product terms can be true on the edge where cfg_mode_i has just dropped. The bench drops cfg_mode_i while inputs are set that would load 1 into the registered cells. It requires the pins to show a cleared register after that edge and the captured value only on the following edge. The toggling cell and its feedback-driven neighbour also check that held state survives configuration mode unchanged.

// File: rtl/pal_pkg.sv
package pal_pkg;
  localparam int NUM_CELL      = 8;
  localparam int TERMS_PER_CEL = 8;
  localparam int NUM_ROW       = NUM_CELL * TERMS_PER_CEL;
  localparam int COL_PER_SLOT  = 4;
  localparam int NUM_SLOT      = 8;
  localparam int NUM_COL       = NUM_SLOT * COL_PER_SLOT;
  localparam int ROW_AW        = $clog2(NUM_ROW);
  localparam int COL_AW        = $clog2(NUM_COL);
  localparam int FUSE_AW       = ROW_AW + COL_AW;

  typedef logic [NUM_COL-1:0] row_fuse_t;

  function automatic bit cell_is_reg(int num_regs, int m);
    int first;
    first = (NUM_CELL - num_regs) / 2;
    return (num_regs != 0) && (m >= first) && (m < first + num_regs);
  endfunction
endpackage

// File: rtl/pal_fuse_store.sv
module pal_fuse_store
  import pal_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cfg_i,
  input  logic                   we_i,
  input  logic [FUSE_AW-1:0]     addr_i,
  input  logic                   data_i,
  output row_fuse_t              fuse_o [NUM_ROW]
);
  row_fuse_t fuse_q [NUM_ROW];
  logic [ROW_AW-1:0] row_sel;
  logic [COL_AW-1:0] col_sel;

  assign row_sel = addr_i[FUSE_AW-1:COL_AW];
  assign col_sel = addr_i[COL_AW-1:0];

  for (genvar r = 0; r < NUM_ROW; r++) begin : g_row
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        fuse_q[r] <= '1;
      end else if (cfg_i && we_i && (row_sel == ROW_AW'(r))) begin
        fuse_q[r][col_sel] <= data_i;
      end
    end
    assign fuse_o[r] = fuse_q[r];

    p_run_write_ignored_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cfg_i |=> $stable(fuse_o[r]));
  end
endmodule

// File: rtl/pal_term_array.sv
module pal_term_array
  import pal_pkg::*;
(
  input  logic [NUM_COL-1:0] lits_i,
  input  row_fuse_t          fuse_i [NUM_ROW],
  output logic [NUM_ROW-1:0] term_o
);
  // intact fuse (1) requires its literal to be 1
  for (genvar r = 0; r < NUM_ROW; r++) begin : g_term
    assign term_o[r] = &(lits_i | ~fuse_i[r]);
  end
endmodule

// File: rtl/pal_macrocell.sv
module pal_macrocell
  import pal_pkg::*;
#(
  parameter bit IS_REG = 1'b0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     hold_i,
  input  logic                     clr_i,
  input  logic                     oe_ni,
  input  logic [TERMS_PER_CEL-1:0] terms_i,
  input  logic                     ext_fb_i,
  output logic                     pin_o,
  output logic                     pin_oe_o,
  output logic                     fb_o
);
  if (IS_REG) begin : g_reg
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      q <= 1'b0;
      else if (clr_i)   q <= 1'b0;
      else if (!hold_i) q <= |terms_i;
    end
    assign pin_o    = ~q;
    assign pin_oe_o = ~oe_ni & ~hold_i;
    assign fb_o     = q;

    p_capture_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!hold_i && !clr_i) |=> (pin_o == !$past(|terms_i)));
    p_hold_state_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hold_i |=> $stable(pin_o));
    p_leave_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> (pin_o && !fb_o));
  end else begin : g_comb
    logic sum;
    assign sum      = |terms_i[TERMS_PER_CEL-1:1];
    assign pin_o    = ~sum;
    assign pin_oe_o = terms_i[0] & ~hold_i;
    assign fb_o     = ext_fb_i;
  end

  p_cfg_no_drive_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |-> !pin_oe_o);
endmodule

// File: rtl/pal_array.sv
module pal_array
  import pal_pkg::*;
#(
  parameter int NUM_REGS = 4,
  localparam int NUM_IN  = (NUM_REGS == 0) ? NUM_SLOT + 2 : NUM_SLOT
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_mode_i,
  input  logic               fuse_we_i,
  input  logic [FUSE_AW-1:0] fuse_addr_i,
  input  logic               fuse_data_i,
  input  logic [NUM_IN-1:0]  in_i,
  input  logic               oe_ni,
  input  logic [NUM_CELL-1:0] pin_i,
  output logic [NUM_CELL-1:0] pin_o,
  output logic [NUM_CELL-1:0] pin_oe_o
);
  row_fuse_t           fuse [NUM_ROW];
  logic [NUM_COL-1:0]  lits;
  logic [NUM_ROW-1:0]  terms;
  logic [NUM_CELL-1:0] fb;
  logic [NUM_CELL-1:0] ext_fb;
  logic                cfg_q;
  logic                leave;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= 1'b0;
    else         cfg_q <= cfg_mode_i;
  end
  assign leave = cfg_q & ~cfg_mode_i;

  pal_fuse_store i_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cfg_i  (cfg_mode_i),
    .we_i   (fuse_we_i),
    .addr_i (fuse_addr_i),
    .data_i (fuse_data_i),
    .fuse_o (fuse)
  );

  for (genvar k = 0; k < NUM_SLOT; k++) begin : g_slot
    assign lits[COL_PER_SLOT*k]     = in_i[k];
    assign lits[COL_PER_SLOT*k + 1] = ~in_i[k];
    assign lits[COL_PER_SLOT*k + 2] = fb[k];
    assign lits[COL_PER_SLOT*k + 3] = ~fb[k];
  end

  pal_term_array i_terms (
    .lits_i (lits),
    .fuse_i (fuse),
    .term_o (terms)
  );

  for (genvar m = 0; m < NUM_CELL; m++) begin : g_cell
    if (NUM_REGS == 0 && m == 0) begin : g_ded_lo
      assign ext_fb[m] = in_i[NUM_IN-2];
    end else if (NUM_REGS == 0 && m == NUM_CELL-1) begin : g_ded_hi
      assign ext_fb[m] = in_i[NUM_IN-1];
    end else begin : g_pad
      assign ext_fb[m] = pin_i[m];
    end

    pal_macrocell #(.IS_REG(cell_is_reg(NUM_REGS, m))) i_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .hold_i   (cfg_mode_i),
      .clr_i    (leave),
      .oe_ni    (oe_ni),
      .terms_i  (terms[TERMS_PER_CEL*m +: TERMS_PER_CEL]),
      .ext_fb_i (ext_fb[m]),
      .pin_o    (pin_o[m]),
      .pin_oe_o (pin_oe_o[m]),
      .fb_o     (fb[m])
    );
  end

  p_leave_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    leave |=> !leave);
  p_cfg_all_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_mode_i |-> (pin_oe_o == '0));
endmodule

// File: tb/test_pal_array.sv
module test_pal_array;
  logic        clk = 1'b0;
  logic        rst_n, cfg, we, wdat, oe_n;
  logic [10:0] addr;
  logic [9:0]  in_v;
  logic [7:0]  pin_in;
  logic [7:0]  po_r, poe_r, po_c, poe_c;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pal_array #(.NUM_REGS(4)) i_pal_array (
    .clk_i(clk), .rst_ni(rst_n), .cfg_mode_i(cfg), .fuse_we_i(we),
    .fuse_addr_i(addr), .fuse_data_i(wdat), .in_i(in_v[7:0]), .oe_ni(oe_n),
    .pin_i(pin_in), .pin_o(po_r), .pin_oe_o(poe_r));

  pal_array #(.NUM_REGS(0)) i_pal_array_comb (
    .clk_i(clk), .rst_ni(rst_n), .cfg_mode_i(cfg), .fuse_we_i(we),
    .fuse_addr_i(addr), .fuse_data_i(wdat), .in_i(in_v), .oe_ni(oe_n),
    .pin_i(pin_in), .pin_o(po_c), .pin_oe_o(poe_c));

  // {in[7:0], pin7, exp o0, exp o1, exp o6, exp oe1}
  localparam logic [12:0] VEC [7] = '{
    {8'b0000_0000, 1'b0, 4'b1110},
    {8'b0000_0001, 1'b0, 4'b0110},
    {8'b0000_0010, 1'b1, 4'b0100},
    {8'b0000_0110, 1'b0, 4'b1110},
    {8'b0011_1000, 1'b0, 4'b1011},
    {8'b0010_1000, 1'b1, 4'b1101},
    {8'b0011_0111, 1'b0, 4'b0010}
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put_row(int row, logic [31:0] keep);
    for (int c = 0; c < 32; c++) begin
      @(posedge clk); #1;
      we = 1'b1; addr = {row[5:0], c[4:0]}; wdat = keep[c];
    end
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst_n = 0; cfg = 0; we = 0; wdat = 0; addr = '0; in_v = '0; oe_n = 1; pin_in = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1 reset pins", {po_r, poe_r}, {8'hFF, 8'h00});
    chk("R1 reset comb pins", {po_c, poe_c}, {8'hFF, 8'h00});

    @(posedge clk); #1 cfg = 1; oe_n = 0;
    @(negedge clk);
    chk("R8 cfg forces enables off", poe_r, 8'h00);

    put_row(0,  32'h0000_0000);             // cell0 enable always
    put_row(1,  32'h0000_0001);             // in0
    put_row(2,  32'h0000_0210);             // in1 & ~in2
    put_row(3,  32'h0000_0004);             // fb slot0
    put_row(8,  32'h0000_1000);             // cell1 enable in3
    put_row(9,  32'h0011_0000);             // in4 & in5
    put_row(16, 32'h0100_0000);             // cell2: in6
    put_row(17, 32'h0000_4000);             // cell2: fb cell3
    put_row(24, 32'h1000_8000);             // cell3: in7 & ~fb3
    put_row(48, 32'h0000_0000);             // cell6 enable always
    put_row(49, 32'h4000_0000);             // fb slot7
    @(posedge clk); #1 cfg = 0;
    @(posedge clk); #1;

    foreach (VEC[i]) begin
      in_v = {2'b00, VEC[i][12:5]};
      pin_in = {VEC[i][4], 7'b0};
      @(negedge clk);
      chk("R5 cell0 sum", po_r[0], VEC[i][3]);
      chk("R5 cell1 sum", po_r[1], VEC[i][2]);
      chk("R7 cell6 pad feedback", po_r[6], VEC[i][1]);
      chk("R5 cell1 enable term", poe_r[1], VEC[i][0]);
      chk("R3 intact row false", {po_r[7], poe_r[7], poe_r[0], poe_r[6]}, 4'b1011);
      @(posedge clk); #1;
    end

    // R2: run-mode write would make cell0 enable depend on in0
    in_v = '0; pin_in = '0;
    we = 1; addr = 11'd0; wdat = 1'b1;
    @(posedge clk); #1 we = 0;
    @(negedge clk);
    chk("R2 run write ignored", poe_r[0], 1'b1);

    // R6/R7/R9: cell3 toggles on in7, cell2 follows cell3 feedback
    @(posedge clk); #1 in_v = 10'h080;
    @(posedge clk); @(negedge clk);
    chk("R6 edge1 q3=1 q2=0", po_r[3:2], 2'b01);
    @(posedge clk); @(negedge clk);
    chk("R7 edge2 q3=0 q2=1", po_r[3:2], 2'b10);
    @(posedge clk); @(negedge clk);
    chk("R6 edge3 q3=1 q2=0", po_r[3:2], 2'b01);
    chk("R9 registered cells 2..5 enabled", poe_r[5:2], 4'hF);
    chk("R9 unused regs idle", po_r[5:4], 2'b11);
    #1 oe_n = 1;
    @(negedge clk);
    chk("R6 shared enable off", poe_r[5:2], 4'h0);

    // R8: hold in config, clear on the leaving edge
    @(posedge clk); #1 cfg = 1; in_v = 10'h0C0;
    @(posedge clk); @(negedge clk);
    chk("R8 hold edge1", po_r[3:2], 2'b01);
    chk("R8 enables off", poe_r, 8'h00);
    @(posedge clk); @(negedge clk);
    chk("R8 hold edge2", po_r[3:2], 2'b01);
    #1 cfg = 0;
    @(posedge clk); @(negedge clk);
    chk("R8 leave clears regs", po_r[3:2], 2'b11);
    @(posedge clk); @(negedge clk);
    chk("R6 capture after leave", po_r[3:2], 2'b00);

    // R9: all-combinational flavour uses in8/in9 as feedback of cells 0/7
    #1 in_v = 10'h300;
    @(negedge clk);
    chk("R9 comb in8 in9", {po_c[0], po_c[6]}, 2'b00);
    chk("R9 comb enables", {poe_c[0], poe_c[6]}, 2'b11);
    chk("R4 main cell0 ignores in8", po_r[0], 1'b1);

    summary();
  end
endmodule